// File: doc/BRIEF.md
# Indirect Branch Target Predictor with Path-Hashed Indexing

This block is a set-associative table that predicts where an indirect branch will jump. Each entry pairs a partial branch-address tag with a full target address. The set that holds an entry is not chosen by the branch address alone. The aligned branch address is XORed with the global branch-history value. It is also XORed with the targets of the most recent indirect branches, each shifted further right the older it is. As a result, one branch can hold several targets at once, one for each history or path context.

The fetch side drives the lookup port with a branch address, a history value and the recent path targets. It receives a hit flag and a predicted target in the same cycle. The resolve side drives the update port with the same three index inputs and the resolved target. If a valid way in the indexed set holds the same tag, the write replaces that way's target. Otherwise it installs the tag and target in a way chosen by a free-running pseudo-random generator. The caller keeps the path history; it arrives as a packed vector with one valid bit per slot.

Top module: `itc_predictor`

## Requirements
- R1: The set index is the branch PC shifted right by INST_SHIFT (default 2), XORed with the other enabled terms, keeping the low log2(SETS) bits (default 16 sets, 4 index bits). PC bits below INST_SHIFT have no effect on the index or the tag.
- R2: With HASH_GHR set (default), the history input, zero-extended, is XORed into the index hash, so the same PC with a different history selects a different set.
- R3: With HASH_PATH set (default), each path slot p whose valid bit is 1 contributes its target shifted right by INST_SHIFT + p*(log2(SETS)/PATH_LEN). Slot 0 is the newest and occupies bits [PC_W-1:0] of the path vector; slot p occupies bits [p*PC_W +: PC_W]. A slot with a clear valid bit contributes nothing.
- R4: The tag is the low TAG_W bits (default 10) of PC >> INST_SHIFT. A lookup hits only on a valid way in the indexed set with an equal tag, so PCs that differ only above those tag bits alias.
- R5: A lookup is combinational: lk_hit and lk_target reflect the table in the same cycle, and lk_target is the stored target of the matching way.
- R6: An update whose tag matches a valid way in its set overwrites that way's target and allocates no second way, so a later lookup returns the newest target.
- R7: An update that matches no way writes tag and target into a way picked by a 16-bit LFSR that never reaches zero. The entry just written hits on the next lookup, and at most WAYS distinct tags stay resident in one set.
- R8: Reset clears every valid bit, so no lookup hits afterwards, including PC 0, whose tag is zero.
- R9: When a lookup and an update use the same set in one cycle, the lookup sees the contents from before the update, and the write shows from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Branch address to predict |
| lk_ghr | input | GHR_W | Global history for the lookup |
| lk_path | input | PATH_LEN*PC_W | Recent indirect targets, slot 0 newest in the low bits |
| lk_path_vld | input | PATH_LEN | Valid bit per lookup path slot |
| lk_hit | output | 1 | A valid way matched |
| lk_target | output | PC_W | Predicted target, zero on a miss |
| up_en | input | 1 | Write the resolved target this cycle |
| up_pc | input | PC_W | Branch address being trained |
| up_ghr | input | GHR_W | Global history for the update |
| up_path | input | PATH_LEN*PC_W | Path targets for the update |
| up_path_vld | input | PATH_LEN | Valid bit per update path slot |
| up_target | input | PC_W | Resolved target |

## Verification
Two situations are hardest to reach from the ports. The first is a set under pressure from more tags than it has ways, where the victim depends on LFSR state that the bench cannot see. The bench pushes six distinct tags into one set. It checks that the newest always hits and that no more than WAYS of them remain, without predicting which ones were evicted. The second is a single branch whose index moves with path context. Here the bench trains one PC under one path slot and probes it with the same contribution delivered from an older slot, where the wider shift lands it in the same set. It also probes with the slot masked off, and with a value that shifts out to nothing.

// File: rtl/itc_pkg.sv
package itc_pkg;

  localparam int RND_W = 16;

  // Galois step, feedback polynomial x^16+x^14+x^13+x^11+1
  function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] s);
    return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
  endfunction

endpackage

// File: rtl/itc_hash.sv
module itc_hash #(
  parameter int PC_W       = 32,
  parameter int GHR_W      = 8,
  parameter int SET_W      = 4,
  parameter int TAG_W      = 10,
  parameter int PATH_LEN   = 2,
  parameter int INST_SHIFT = 2,
  parameter bit HASH_GHR   = 1'b1,
  parameter bit HASH_PATH  = 1'b1
) (
  input  logic [PC_W-1:0]          pc,
  input  logic [GHR_W-1:0]         ghr,
  input  logic [PATH_LEN*PC_W-1:0] path,
  input  logic [PATH_LEN-1:0]      path_vld,
  output logic [SET_W-1:0]         set_idx,
  output logic [TAG_W-1:0]         tag
);
  localparam int AGE_STEP = SET_W / PATH_LEN;

  logic [PC_W-1:0] pc_al;
  logic [PC_W-1:0] mix [PATH_LEN+1];

  assign pc_al  = pc >> INST_SHIFT;
  assign mix[0] = pc_al ^ (HASH_GHR ? PC_W'(ghr) : '0);

  for (genvar p = 0; p < PATH_LEN; p++) begin : g_age
    assign mix[p+1] = mix[p] ^ ((HASH_PATH && path_vld[p])
                      ? (path[p*PC_W +: PC_W] >> (INST_SHIFT + p*AGE_STEP))
                      : '0);
  end

  assign set_idx = SET_W'(mix[PATH_LEN]);
  assign tag     = TAG_W'(pc_al);
endmodule

// File: rtl/itc_victim_rng.sv
module itc_victim_rng #(
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [WAY_W-1:0] victim
);
  import itc_pkg::*;

  logic [RND_W-1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= 16'hACE1;
    else        state_q <= rnd_step(state_q);
  end

  always_comb begin
    victim = '0;
    for (int i = 0; i < RND_W; i++) victim[i % WAY_W] ^= state_q[i];
  end

  // R7
  rng_alive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
endmodule

// File: rtl/itc_predictor.sv
module itc_predictor #(
  parameter int PC_W       = 32,
  parameter int GHR_W      = 8,
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int TAG_W      = 10,
  parameter int PATH_LEN   = 2,
  parameter int INST_SHIFT = 2,
  parameter bit HASH_GHR   = 1'b1,
  parameter bit HASH_PATH  = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PC_W-1:0]          lk_pc,
  input  logic [GHR_W-1:0]         lk_ghr,
  input  logic [PATH_LEN*PC_W-1:0] lk_path,
  input  logic [PATH_LEN-1:0]      lk_path_vld,
  output logic                     lk_hit,
  output logic [PC_W-1:0]          lk_target,
  input  logic                     up_en,
  input  logic [PC_W-1:0]          up_pc,
  input  logic [GHR_W-1:0]         up_ghr,
  input  logic [PATH_LEN*PC_W-1:0] up_path,
  input  logic [PATH_LEN-1:0]      up_path_vld,
  input  logic [PC_W-1:0]          up_target
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic              vld_q [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [PC_W-1:0]   tgt_q [SETS][WAYS];

  logic [SET_W-1:0]  lk_set, up_set;
  logic [TAG_W-1:0]  lk_tag, up_tag;
  logic [WAYS-1:0]   lk_hit_vec, up_hit_vec;
  logic              up_hit;
  logic [WAY_W-1:0]  up_hit_way, up_way, victim;

  itc_hash #(.PC_W(PC_W), .GHR_W(GHR_W), .SET_W(SET_W), .TAG_W(TAG_W),
             .PATH_LEN(PATH_LEN), .INST_SHIFT(INST_SHIFT),
             .HASH_GHR(HASH_GHR), .HASH_PATH(HASH_PATH)) u_lk_hash (
    .pc(lk_pc), .ghr(lk_ghr), .path(lk_path), .path_vld(lk_path_vld),
    .set_idx(lk_set), .tag(lk_tag));

  itc_hash #(.PC_W(PC_W), .GHR_W(GHR_W), .SET_W(SET_W), .TAG_W(TAG_W),
             .PATH_LEN(PATH_LEN), .INST_SHIFT(INST_SHIFT),
             .HASH_GHR(HASH_GHR), .HASH_PATH(HASH_PATH)) u_up_hash (
    .pc(up_pc), .ghr(up_ghr), .path(up_path), .path_vld(up_path_vld),
    .set_idx(up_set), .tag(up_tag));

  itc_victim_rng #(.WAY_W(WAY_W)) u_rng (
    .clk(clk), .rst_n(rst_n), .victim(victim));

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lk_hit_vec[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    assign up_hit_vec[w] = vld_q[up_set][w] && (tag_q[up_set][w] == up_tag);
  end

  always_comb begin
    lk_target  = '0;
    up_hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_hit_vec[w]) lk_target = lk_target | tgt_q[lk_set][w];
      if (up_hit_vec[w]) up_hit_way = WAY_W'(w);
    end
  end

  assign lk_hit = |lk_hit_vec;
  assign up_hit = |up_hit_vec;
  assign up_way = up_hit ? up_hit_way : (victim & WAY_W'(WAYS-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) vld_q[s][w] <= 1'b0;
    end else if (up_en) begin
      vld_q[up_set][up_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (up_en) begin
      tag_q[up_set][up_way] <= up_tag;
      tgt_q[up_set][up_way] <= up_target;
    end
  end

  // R4
  lk_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec));
  // R6
  up_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(up_hit_vec) <= 1);
  // R7
  alloc_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_en |=> vld_q[$past(up_set)][$past(up_way)]);
  // R6
  overwrite_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_en && up_hit |=> tgt_q[$past(up_set)][$past(up_way)] == $past(up_target));
endmodule

// File: tb/tb_itc_predictor.sv
module tb_itc_predictor;
  localparam int PC_W = 32, GHR_W = 8, WAYS = 4;

  logic             clk = 1'b0, rst_n = 1'b0;
  logic [PC_W-1:0]  lk_pc = '0, up_pc = '0, up_target = '0, lk_target;
  logic [GHR_W-1:0] lk_ghr = '0, up_ghr = '0;
  logic [2*PC_W-1:0] lk_path = '0, up_path = '0;
  logic [1:0]       lk_path_vld = '0, up_path_vld = '0;
  logic             lk_hit, up_en = 1'b0;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  itc_predictor dut (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(lk_pc), .lk_ghr(lk_ghr), .lk_path(lk_path), .lk_path_vld(lk_path_vld),
    .lk_hit(lk_hit), .lk_target(lk_target),
    .up_en(up_en), .up_pc(up_pc), .up_ghr(up_ghr), .up_path(up_path),
    .up_path_vld(up_path_vld), .up_target(up_target));

  // PC landing in set s (zero history, no path) with tag bits (t<<4)|s
  function automatic logic [PC_W-1:0] pc_in_set(int t, int s);
    return PC_W'(((t << 4) | s) << 2);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic train(input logic [PC_W-1:0] pc, input logic [GHR_W-1:0] g,
                       input logic [PC_W-1:0] p0, input logic [PC_W-1:0] p1,
                       input logic [1:0] vm, input logic [PC_W-1:0] tgt);
    @(negedge clk);
    up_en = 1'b1; up_pc = pc; up_ghr = g; up_path = {p1, p0};
    up_path_vld = vm; up_target = tgt;
    @(negedge clk);
    up_en = 1'b0;
  endtask

  task automatic probe(input logic [PC_W-1:0] pc, input logic [GHR_W-1:0] g,
                       input logic [PC_W-1:0] p0, input logic [PC_W-1:0] p1,
                       input logic [1:0] vm, output logic h,
                       output logic [PC_W-1:0] t);
    @(negedge clk);
    lk_pc = pc; lk_ghr = g; lk_path = {p1, p0}; lk_path_vld = vm;
    #2;
    h = lk_hit; t = lk_target;
  endtask

  task automatic t_reset();
    logic h; logic [PC_W-1:0] t;
    probe(32'h0, 0, 0, 0, 2'b00, h, t);
    check(!h, "R8 pc0 miss", h, 0);
    probe(32'h100, 0, 0, 0, 2'b00, h, t);
    check(!h, "R8 miss after reset", h, 0);
    probe(32'h3c, 8'h7, 32'h40, 0, 2'b01, h, t);
    check(!h, "R8 miss with history", h, 0);
  endtask

  task automatic t_basic();
    logic h; logic [PC_W-1:0] t;
    train(32'h100, 0, 0, 0, 2'b00, 32'h8000_1000);
    probe(32'h100, 0, 0, 0, 2'b00, h, t);
    check(h, "R5 hit after train", h, 1);
    check(t == 32'h8000_1000, "R5 target", t, 32'h8000_1000);
    probe(32'h103, 0, 0, 0, 2'b00, h, t);
    check(h && t == 32'h8000_1000, "R1 low bits ignored", t, 32'h8000_1000);
    probe(32'h140, 0, 0, 0, 2'b00, h, t);
    check(!h, "R4 tag mismatch same set", h, 0);
    probe(32'h1100, 0, 0, 0, 2'b00, h, t);
    check(h && t == 32'h8000_1000, "R4 alias above tag bits", t, 32'h8000_1000);
  endtask

  task automatic t_ghr();
    logic h; logic [PC_W-1:0] t;
    probe(32'h100, 8'h3, 0, 0, 2'b00, h, t);
    check(!h, "R2 history moves set", h, 0);
    train(32'h200, 8'h5, 0, 0, 2'b00, 32'h4444_0000);
    probe(32'h200, 8'h5, 0, 0, 2'b00, h, t);
    check(h && t == 32'h4444_0000, "R2 hit with history", t, 32'h4444_0000);
    probe(32'h200, 8'h0, 0, 0, 2'b00, h, t);
    check(!h, "R2 miss other history", h, 0);
  endtask

  task automatic t_path();
    logic h; logic [PC_W-1:0] t;
    train(32'h400, 0, 32'h4, 0, 2'b01, 32'hCAFE_0000);
    probe(32'h400, 0, 32'h4, 0, 2'b01, h, t);
    check(h && t == 32'hCAFE_0000, "R3 hit same path", t, 32'hCAFE_0000);
    probe(32'h400, 0, 32'h4, 0, 2'b00, h, t);
    check(!h, "R3 masked slot no effect", h, 0);
    probe(32'h400, 0, 0, 32'h10, 2'b10, h, t);
    check(h, "R3 older slot wider shift", h, 1);
    probe(32'h400, 0, 32'h4, 32'h10, 2'b11, h, t);
    check(!h, "R3 two slots cancel", h, 0);
    probe(32'h400, 0, 0, 32'h4, 2'b10, h, t);
    check(!h, "R3 older slot shifts out", h, 0);
  endtask

  task automatic t_overwrite();
    logic h; logic [PC_W-1:0] t;
    train(pc_in_set(3, 9), 0, 0, 0, 2'b00, 32'h1111_0000);
    for (int i = 0; i < 6; i++)
      train(pc_in_set(3, 9), 0, 0, 0, 2'b00, 32'h2222_0000 + PC_W'(i));
    probe(pc_in_set(3, 9), 0, 0, 0, 2'b00, h, t);
    check(h && t == 32'h2222_0005, "R6 newest target", t, 32'h2222_0005);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    up_en = 1'b1; up_pc = pc_in_set(5, 12); up_ghr = 0; up_path_vld = 0;
    up_target = 32'hAAAA_0000;
    lk_pc = pc_in_set(5, 12); lk_ghr = 0; lk_path_vld = 0;
    #2;
    check(!lk_hit, "R9 pre-update miss", lk_hit, 0);
    @(negedge clk);
    up_target = 32'hBBBB_0000;
    #2;
    check(lk_hit && lk_target == 32'hAAAA_0000, "R9 old target same cycle",
          lk_target, 32'hAAAA_0000);
    @(negedge clk);
    up_en = 1'b0;
    #2;
    check(lk_hit && lk_target == 32'hBBBB_0000, "R9 new target next cycle",
          lk_target, 32'hBBBB_0000);
  endtask

  task automatic t_replace();
    logic h; logic [PC_W-1:0] t;
    int hits = 0;
    for (int k = 8; k < 14; k++) begin
      train(pc_in_set(k, 14), 0, 0, 0, 2'b00, 32'h5000_0000 + PC_W'(k));
      probe(pc_in_set(k, 14), 0, 0, 0, 2'b00, h, t);
      check(h && t == 32'h5000_0000 + PC_W'(k), "R7 newest resident", t,
            32'h5000_0000 + PC_W'(k));
    end
    for (int k = 8; k < 14; k++) begin
      probe(pc_in_set(k, 14), 0, 0, 0, 2'b00, h, t);
      if (h) hits++;
    end
    check(hits >= 1 && hits <= WAYS, "R7 resident count", hits, WAYS);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_basic();
    t_ghr();
    t_path();
    t_overwrite();
    t_same_cycle();
    t_replace();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule